// File: doc/BRIEF.md
# Interrupting GPIO Bank

This block is a bank of general-purpose pins controlled through a small word-indexed register bus. For each pin, software chooses whether the pin drives or listens, what value it drives, whether it flashes from a shared slow timebase, and whether its input is treated as active-high or active-low. The pin level is passed through a synchroniser and then inverted where the polarity bit asks for it. That adjusted level is what software reads back, and it is also what the interrupt logic sees.

Interrupts come in two kinds. Level interrupts follow the adjusted input while their mask bit is set. Edge interrupts latch a rising transition of the adjusted input into a sticky cause bit, and software clears that bit by writing a zero to its position. The pending bits are ORed in groups of eight pins onto separate summary lines, so an interrupt controller can tell which quarter of the bank needs attention. The pads are shown as three vectors: drive value, drive enable and sampled input.

Top module: `gpio_irq_bank`

## Requirements
- R1: The eight registers are selected by a word index equal to the byte offset divided by four: output data 0 (0x00), direction 1 (0x04), blink enable 2 (0x08), input polarity 3 (0x0C), data in 4 (0x10), edge cause 5 (0x14), edge mask 6 (0x18), level mask 7 (0x1C). A value written to output data, direction, blink enable, polarity or either mask reads back unchanged.
- R2: A pin whose direction bit is 1 is an input: its drive enable is 0 and its drive value is 0. A direction bit of 0 sets drive enable to 1, and the drive value comes from the output data bit.
- R3: Reading data in returns the pad input, delayed by two synchroniser flops, XORed with the polarity bits. Writes to data in have no effect.
- R4: A cause bit sets one clock after the adjusted input of its pin goes from 0 to 1, which is three clocks after the pad changes. With polarity 1, this means a falling pad edge sets the bit.
- R5: A write to edge cause clears each bit where the written data has a 0 and leaves each bit where it has a 1. A cause bit that sets in the same cycle as a clearing write stays set. Cause bits never clear without a write to this register.
- R6: The pending bit of pin i is (adjusted input AND level mask) OR (cause AND edge mask). Output irq[k] is the OR of the pending bits of pins 8k to 8k+7, with no register delay.
- R7: A pin that is an output and has blink enabled drives a shared phase signal in place of its output data bit. The phase starts at 0 after reset and inverts every BLINK_HALF clocks.
- R8: Reset is synchronous and active low. After reset, every pin is an input, and output data, blink enable, polarity, edge cause, both masks and read data are all zero.
- R9: Read data is registered. It shows the addressed register one clock after rd_en, using the state from before any write in that same cycle, and it holds its value while rd_en is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe for one cycle |
| rd_en | input | 1 | Read strobe for one cycle |
| reg_idx | input | 3 | Word index of the register |
| wdata | input | NPINS | Write data, one bit per pin |
| rdata | output | NPINS | Registered read data |
| pad_in | input | NPINS | Sampled pad levels (asynchronous) |
| pad_out | output | NPINS | Pad drive values |
| pad_oe | output | NPINS | Pad drive enables |
| irq | output | NPINS/GRP | Summary interrupt per pin group |

## Verification
The bench builds the bank with 32 pins in groups of eight, which exercises all four summary lines. It sets the blink half period to six clocks, so several full phase periods fit into a short directed window and the toggle count can be checked exactly. A behavioural model tracks the synchroniser stages, the previous adjusted level and the blink counter bit by bit. With that model, the three-clock edge latency and the case where a set and a clear land in the same cycle can be timed down to the exact edge.

// File: rtl/gpio_bank_pkg.sv
// Shared definitions for the GPIO bank: register word indices.
// Assumes the bus presents a word index, not a byte address.
package gpio_bank_pkg;
    localparam int REG_IDX_W = 3;

    typedef enum logic [REG_IDX_W-1:0] {
        REG_DOUT  = 3'd0,
        REG_DIR   = 3'd1,
        REG_BLINK = 3'd2,
        REG_POL   = 3'd3,
        REG_DIN   = 3'd4,
        REG_CAUSE = 3'd5,
        REG_EMASK = 3'd6,
        REG_LMASK = 3'd7
    } gpio_reg_e;
endpackage

// File: rtl/gpio_pin_sync.sv
// Multi-stage synchroniser for a vector of asynchronous pad inputs.
// Assumes each bit is independent; no bus coherence is implied.
module gpio_pin_sync #(
    parameter int WIDTH  = 32,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [STAGES-1:0][WIDTH-1:0] stage_q;

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            // Shift one synchroniser stage per clock.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    stage_q[s] <= '0;
                else if (s == 0)
                    stage_q[s] <= async_in;
                else
                    stage_q[s] <= stage_q[(s > 0) ? s - 1 : 0];
            end
        end
    endgenerate

    assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_blink_timer.sv
// Free-running blink timebase: phase inverts every HALF_CYCLES clocks.
// Assumes HALF_CYCLES >= 1.
module gpio_blink_timer #(
    parameter int HALF_CYCLES = 25000000
) (
    input  logic clk,
    input  logic rst_n,
    output logic phase,
    output logic wrap
);
    localparam int CW = (HALF_CYCLES > 1) ? $clog2(HALF_CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF_CYCLES - 1);

    logic [CW-1:0] count_q;
    logic          phase_q;

    assign wrap  = (count_q == LAST);
    assign phase = phase_q;

    // Count clocks and invert the phase on each wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
            phase_q <= 1'b0;
        end else if (wrap) begin
            count_q <= '0;
            phase_q <= ~phase_q;
        end else begin
            count_q <= count_q + 1'b1;
        end
    end
endmodule

// File: rtl/gpio_edge_cause.sv
// Sticky edge cause register with write-zero-to-clear.
// Latches rising transitions of the adjusted level; a set beats a clear.
module gpio_edge_cause #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] level,
    input  logic             clr_we,
    input  logic [WIDTH-1:0] clr_keep,
    output logic [WIDTH-1:0] cause,
    output logic [WIDTH-1:0] rise
);
    logic [WIDTH-1:0] level_q;
    logic [WIDTH-1:0] cause_q;
    logic [WIDTH-1:0] kept;

    assign rise  = level & ~level_q;
    assign kept  = clr_we ? (cause_q & clr_keep) : cause_q;
    assign cause = cause_q;

    // Remember the previous adjusted level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n)
            level_q <= '0;
        else
            level_q <= level;
    end

    // Update cause bits: keep or clear, then OR in new edges.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cause_q <= '0;
        else
            cause_q <= kept | rise;
    end
endmodule

// File: rtl/gpio_irq_summary.sv
// Combines pending bits and ORs them into one line per pin group.
// Assumes WIDTH is a multiple of GRP.
module gpio_irq_summary #(
    parameter int WIDTH = 32,
    parameter int GRP   = 8
) (
    input  logic [WIDTH-1:0]     level,
    input  logic [WIDTH-1:0]     level_mask,
    input  logic [WIDTH-1:0]     cause,
    input  logic [WIDTH-1:0]     edge_mask,
    output logic [WIDTH/GRP-1:0] irq
);
    localparam int NGRP = WIDTH / GRP;

    logic [WIDTH-1:0] pending;

    assign pending = (level & level_mask) | (cause & edge_mask);

    genvar g;
    generate
        for (g = 0; g < NGRP; g++) begin : g_grp
            assign irq[g] = |pending[g*GRP +: GRP];
        end
    endgenerate
endmodule

// File: rtl/gpio_irq_bank.sv
// GPIO bank top: register file, pad drive, blink, input polarity and
// grouped interrupt summary. Assumes a single-cycle write and read strobe
// on a word-indexed bus; pad inputs are asynchronous.
module gpio_irq_bank
    import gpio_bank_pkg::*;
#(
    parameter int NPINS       = 32,
    parameter int GRP         = 8,
    parameter int BLINK_HALF  = 25000000,
    parameter int SYNC_STAGES = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic                   rd_en,
    input  logic [REG_IDX_W-1:0]   reg_idx,
    input  logic [NPINS-1:0]       wdata,
    output logic [NPINS-1:0]       rdata,
    input  logic [NPINS-1:0]       pad_in,
    output logic [NPINS-1:0]       pad_out,
    output logic [NPINS-1:0]       pad_oe,
    output logic [NPINS/GRP-1:0]   irq
);
    localparam int NGRP = NPINS / GRP;

    gpio_reg_e        sel;
    logic [NPINS-1:0] dout_q, dir_q, blink_q, pol_q, emask_q, lmask_q;
    logic [NPINS-1:0] rdata_q;
    logic [NPINS-1:0] pin_sync, adj_level, cause_q, edge_hit;
    logic             phase, wrap;
    logic             cause_we;

    assign sel      = gpio_reg_e'(reg_idx);
    assign cause_we = wr_en && (sel == REG_CAUSE);

    gpio_pin_sync #(.WIDTH(NPINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pad_in),
        .sync_out (pin_sync)
    );

    assign adj_level = pin_sync ^ pol_q;

    gpio_blink_timer #(.HALF_CYCLES(BLINK_HALF)) u_blink (
        .clk   (clk),
        .rst_n (rst_n),
        .phase (phase),
        .wrap  (wrap)
    );

    gpio_edge_cause #(.WIDTH(NPINS)) u_cause (
        .clk      (clk),
        .rst_n    (rst_n),
        .level    (adj_level),
        .clr_we   (cause_we),
        .clr_keep (wdata),
        .cause    (cause_q),
        .rise     (edge_hit)
    );

    gpio_irq_summary #(.WIDTH(NPINS), .GRP(GRP)) u_irq (
        .level      (adj_level),
        .level_mask (lmask_q),
        .cause      (cause_q),
        .edge_mask  (emask_q),
        .irq        (irq)
    );

    // Writable control registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout_q  <= '0;
            dir_q   <= '1;
            blink_q <= '0;
            pol_q   <= '0;
            emask_q <= '0;
            lmask_q <= '0;
        end else if (wr_en) begin
            case (sel)
                REG_DOUT:  dout_q  <= wdata;
                REG_DIR:   dir_q   <= wdata;
                REG_BLINK: blink_q <= wdata;
                REG_POL:   pol_q   <= wdata;
                REG_EMASK: emask_q <= wdata;
                REG_LMASK: lmask_q <= wdata;
                default:   ;
            endcase
        end
    end

    // Registered read mux, sampling pre-write state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (rd_en) begin
            case (sel)
                REG_DOUT:  rdata_q <= dout_q;
                REG_DIR:   rdata_q <= dir_q;
                REG_BLINK: rdata_q <= blink_q;
                REG_POL:   rdata_q <= pol_q;
                REG_DIN:   rdata_q <= adj_level;
                REG_CAUSE: rdata_q <= cause_q;
                REG_EMASK: rdata_q <= emask_q;
                REG_LMASK: rdata_q <= lmask_q;
                default:   rdata_q <= '0;
            endcase
        end
    end

    // Pad drive: blink phase or data, gated by the driver enable.
    always_comb begin
        pad_oe  = ~dir_q;
        pad_out = ~dir_q & ((blink_q & {NPINS{phase}}) | (~blink_q & dout_q));
    end

    assign rdata = rdata_q;

    // The group count must cover every pin exactly.
    initial begin
        if (NGRP * GRP != NPINS)
            $error("NPINS must be a multiple of GRP");
    end
endmodule

// File: rtl/gpio_irq_bank_chk.sv
// Property checker for the GPIO bank, attached by bind.
// Observes ports plus the cause, edge and blink internals.
module gpio_irq_bank_chk #(
    parameter int NPINS = 32,
    parameter int NGRP  = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic             rd_en,
    input logic [2:0]       reg_idx,
    input logic [NPINS-1:0] wdata,
    input logic [NPINS-1:0] rdata,
    input logic [NPINS-1:0] pad_out,
    input logic [NPINS-1:0] pad_oe,
    input logic [NGRP-1:0]  irq,
    input logic [NPINS-1:0] cause_q,
    input logic [NPINS-1:0] edge_hit,
    input logic [NPINS-1:0] emask_q,
    input logic [NPINS-1:0] lmask_q,
    input logic             phase,
    input logic             wrap
);
    logic cause_wr;
    assign cause_wr = wr_en && (reg_idx == 3'd5);

    // R2: an input pin never has a drive value
    a_r2_no_drive_input: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_out & ~pad_oe) == '0);

    // R5: after a clearing write only kept or newly set bits remain
    a_r5_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
        cause_wr |=> ((cause_q & ~$past(wdata) & ~$past(edge_hit)) == '0));

    // R5: without a write, no cause bit falls
    a_r5_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !cause_wr |=> ((~cause_q & $past(cause_q)) == '0));

    // R6: with both masks clear no summary line is raised
    a_r6_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (emask_q == '0 && lmask_q == '0) |-> (irq == '0));

    // R7: the blink phase only changes on a counter wrap
    a_r7_phase_step: assert property (@(posedge clk) disable iff (!rst_n)
        !wrap |=> $stable(phase));

    // R8: first cycle out of reset shows inputs only and no cause
    a_r8_reset_state: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (pad_oe == '0 && cause_q == '0 && rdata == '0));

    // R9: read data holds while no read is issued
    a_r9_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rdata));
endmodule

bind gpio_irq_bank gpio_irq_bank_chk #(.NPINS(NPINS), .NGRP(NPINS/GRP)) i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .rd_en    (rd_en),
    .reg_idx  (reg_idx),
    .wdata    (wdata),
    .rdata    (rdata),
    .pad_out  (pad_out),
    .pad_oe   (pad_oe),
    .irq      (irq),
    .cause_q  (cause_q),
    .edge_hit (edge_hit),
    .emask_q  (emask_q),
    .lmask_q  (lmask_q),
    .phase    (phase),
    .wrap     (wrap)
);

// File: tb/test_gpio_irq_bank.sv
// Bench for the GPIO bank: behavioural per-bit model compared every clock,
// plus directed checks on each requirement.
module test_gpio_irq_bank;
    localparam int CLK_PERIOD = 10;
    localparam int NP   = 32;
    localparam int HALF = 6;
    localparam int NG   = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic          rd_en = 1'b0;
    logic [2:0]    reg_idx = '0;
    logic [NP-1:0] wdata = '0;
    logic [NP-1:0] pad_in = '0;
    logic [NP-1:0] rdata, pad_out, pad_oe;
    logic [NG-1:0] irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_irq_bank #(.NPINS(NP), .GRP(8), .BLINK_HALF(HALF)) i_gpio_irq_bank (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
        .reg_idx(reg_idx), .wdata(wdata), .rdata(rdata),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .irq(irq)
    );

    task automatic check(input string req, input string what,
                         input logic [NP-1:0] act, input logic [NP-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    logic [NP-1:0] m_out, m_dir, m_blk, m_pol, m_em, m_lm, m_cause;
    logic [NP-1:0] m_s1, m_s2, m_prev, m_rdata;
    int            m_cnt;
    bit            m_ph;

    always @(posedge clk) begin
        logic [NP-1:0] adj;
        logic [NP-1:0] nc;
        if (!rst_n) begin
            m_out = '0; m_dir = '1; m_blk = '0; m_pol = '0;
            m_em = '0; m_lm = '0; m_cause = '0; m_s1 = '0; m_s2 = '0;
            m_prev = '0; m_rdata = '0; m_cnt = 0; m_ph = 1'b0;
        end else begin
            for (int i = 0; i < NP; i++) adj[i] = (m_s2[i] != m_pol[i]);
            if (rd_en) begin
                case (reg_idx)
                    3'd0: m_rdata = m_out;
                    3'd1: m_rdata = m_dir;
                    3'd2: m_rdata = m_blk;
                    3'd3: m_rdata = m_pol;
                    3'd4: m_rdata = adj;
                    3'd5: m_rdata = m_cause;
                    3'd6: m_rdata = m_em;
                    default: m_rdata = m_lm;
                endcase
            end
            for (int i = 0; i < NP; i++)
                nc[i] = (m_cause[i] && !(wr_en && reg_idx == 3'd5 && !wdata[i]))
                        || (adj[i] && !m_prev[i]);
            if (wr_en) begin
                case (reg_idx)
                    3'd0: m_out = wdata;
                    3'd1: m_dir = wdata;
                    3'd2: m_blk = wdata;
                    3'd3: m_pol = wdata;
                    3'd6: m_em  = wdata;
                    3'd7: m_lm  = wdata;
                    default: ;
                endcase
            end
            m_cause = nc;
            m_prev  = adj;
            m_s2    = m_s1;
            m_s1    = pad_in;
            if (m_cnt == HALF - 1) begin
                m_cnt = 0;
                m_ph  = !m_ph;
            end else begin
                m_cnt++;
            end
        end
    end

    function automatic logic [NP-1:0] exp_pad_out();
        logic [NP-1:0] v;
        for (int i = 0; i < NP; i++)
            v[i] = m_dir[i] ? 1'b0 : (m_blk[i] ? m_ph : m_out[i]);
        return v;
    endfunction

    function automatic logic [NP-1:0] exp_irq();
        logic [NP-1:0] v = '0;
        for (int g = 0; g < NG; g++)
            for (int j = 0; j < 8; j++) begin
                int i = g * 8 + j;
                if ((((m_s2[i] != m_pol[i]) && m_lm[i])) || (m_cause[i] && m_em[i]))
                    v[g] = 1'b1;
            end
        return v;
    endfunction

    // Compare every clock, away from the active edge.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check("R2", "pad_oe model", pad_oe, ~m_dir);
            check("R7", "pad_out model", pad_out, exp_pad_out());
            check("R6", "irq model", {{(NP-NG){1'b0}}, irq}, exp_irq());
            check("R9", "rdata model", rdata, m_rdata);
        end
    end

    // ---------------- bus tasks ----------------
    task automatic bus_write(input logic [2:0] idx, input logic [NP-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; reg_idx = idx; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic bus_read(input logic [2:0] idx, output logic [NP-1:0] d);
        @(negedge clk);
        rd_en = 1'b1; reg_idx = idx;
        @(negedge clk);
        rd_en = 1'b0;
        d = rdata;
    endtask

    task automatic expect_reg(input string req, input logic [2:0] idx,
                              input logic [NP-1:0] exp);
        logic [NP-1:0] v;
        bus_read(idx, v);
        check(req, $sformatf("reg %0d", idx), v, exp);
    endtask

    // ---------------- directed sequence ----------------
    initial begin
        logic [NP-1:0] dummy;
        int toggles;
        logic prev;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R8: reset state
        check("R8", "pad_oe after reset", pad_oe, '0);
        check("R8", "irq after reset", {{(NP-NG){1'b0}}, irq}, '0);
        check("R8", "rdata after reset", rdata, '0);
        expect_reg("R8", 3'd1, 32'hFFFF_FFFF);
        expect_reg("R8", 3'd0, '0);
        expect_reg("R8", 3'd5, '0);
        expect_reg("R8", 3'd6, '0);
        expect_reg("R8", 3'd7, '0);

        // R1/R2: drive low byte
        bus_write(3'd0, 32'h0000_00A5);
        bus_write(3'd1, 32'hFFFF_FF00);
        check("R2", "oe low byte", pad_oe, 32'h0000_00FF);
        check("R2", "out low byte", pad_out, 32'h0000_00A5);
        expect_reg("R1", 3'd1, 32'hFFFF_FF00);
        expect_reg("R1", 3'd0, 32'h0000_00A5);

        // R3: polarity-adjusted data in; write ignored
        bus_write(3'd3, 32'h0000_0F00);
        @(negedge clk);
        pad_in = 32'h0000_F0F0;
        repeat (3) @(negedge clk);
        expect_reg("R3", 3'd4, 32'h0000_FFF0);
        expect_reg("R1", 3'd3, 32'h0000_0F00);
        bus_write(3'd4, 32'hFFFF_FFFF);
        expect_reg("R3", 3'd4, 32'h0000_FFF0);
        // R4: the adjusted rises latched into cause
        expect_reg("R4", 3'd5, 32'h0000_FFF0);
        bus_write(3'd5, 32'h0000_0000);
        expect_reg("R5", 3'd5, '0);

        // R6: level interrupts by group
        bus_write(3'd7, 32'h0000_0800);
        check("R6", "level irq grp1", {{(NP-NG){1'b0}}, irq}, 32'h2);
        expect_reg("R1", 3'd7, 32'h0000_0800);
        bus_write(3'd7, 32'h0001_0000);
        check("R6", "level irq inactive", {{(NP-NG){1'b0}}, irq}, 32'h0);
        bus_write(3'd7, 32'h0);

        // R4/R6: rising edge pin 20
        bus_write(3'd6, 32'h0010_0000);
        @(negedge clk);
        pad_in[20] = 1'b1;
        repeat (2) @(negedge clk);
        check("R4", "no cause before third clock", {{(NP-NG){1'b0}}, irq}, 32'h0);
        @(negedge clk);
        check("R4", "edge irq grp2", {{(NP-NG){1'b0}}, irq}, 32'h4);
        bus_write(3'd5, 32'hFFFF_FFFF);
        check("R5", "write one keeps", {{(NP-NG){1'b0}}, irq}, 32'h4);
        bus_write(3'd5, ~32'h0010_0000);
        check("R5", "write zero clears", {{(NP-NG){1'b0}}, irq}, 32'h0);

        // R4: falling pad edge with polarity 1 on pin 24
        bus_write(3'd6, 32'h0100_0000);
        bus_write(3'd3, 32'h0100_0F00);
        repeat (3) @(negedge clk);
        bus_write(3'd5, 32'h0);
        @(negedge clk);
        pad_in[24] = 1'b1;
        repeat (4) @(negedge clk);
        expect_reg("R4", 3'd5, 32'h0);
        @(negedge clk);
        pad_in[24] = 1'b0;
        repeat (3) @(negedge clk);
        check("R4", "falling edge irq grp3", {{(NP-NG){1'b0}}, irq}, 32'h8);
        expect_reg("R4", 3'd5, 32'h0100_0000);

        // R5: set beats clear in the same cycle (pin 28)
        bus_write(3'd5, 32'h0);
        bus_write(3'd6, 32'h1000_0000);
        @(negedge clk);
        pad_in[28] = 1'b1;
        @(negedge clk);
        bus_write(3'd5, 32'h0);
        expect_reg("R5", 3'd5, 32'h1000_0000);

        // R7: blink on output pin 4, input pin 5 stays quiet
        bus_write(3'd1, 32'hFFFF_FF20);
        bus_write(3'd2, 32'h0000_0030);
        expect_reg("R1", 3'd2, 32'h0000_0030);
        toggles = 0;
        prev = pad_out[4];
        for (int k = 0; k < 4 * HALF; k++) begin
            @(negedge clk);
            if (pad_out[4] != prev) toggles++;
            prev = pad_out[4];
        end
        check("R7", "blink toggles pin4", 32'(toggles), 32'd4);
        check("R7", "input pin5 blink has no drive", {31'b0, pad_out[5]}, 32'h0);
        check("R2", "input pin5 oe", {31'b0, pad_oe[5]}, 32'h0);

        // R9: rdata holds without a read
        bus_read(3'd1, dummy);
        repeat (3) @(negedge clk);
        check("R9", "rdata hold", rdata, 32'hFFFF_FF20);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL R1 watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule